// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home side of a directory-based coherence scheme for a small pool of memory blocks shared by a fixed number of processors. Every block has a directory entry and a word of backing memory. The entry holds one of three states and a one-bit-per-processor sharer vector. Caches send read misses, write misses and write backs to the controller. It answers with point-to-point messages: invalidations to sharers, fetch or fetch-and-invalidate requests to an owner, and data replies to the requester. It never broadcasts. The sharer vector alone decides who is contacted.

Requests are taken one at a time and run to completion in arrival order. When a block is held dirty by an owner, the controller sends the fetch and drops `req_ready`. It then waits for the owner's copy on the fill port, writes that copy to memory, and only then replies. A requester is expected to block until it sees its data reply.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` is 0, every block is uncached with an empty sharer set, and every memory word reads as 0.
- R2: A read miss (`req_op`=0) to an uncached or shared block produces exactly one data reply (`msg_type`=3) to the requester, carrying the block's memory word. The block becomes shared and the requester is added to its sharers.
- R3: A write miss (`req_op`=1) to an uncached block produces one data reply to the requester. The block becomes exclusive, with the requester as its only owner.
- R4: A write miss to a shared block first sends one invalidate (`msg_type`=0) to each sharer other than the requester, in ascending processor number. It then sends the data reply, and the requester becomes the sole exclusive owner.
- R5: A read miss to an exclusive block sends a fetch (`msg_type`=1) to the owner and waits for the fill. It writes the fill data to memory and replies with that data. The block becomes shared, with both the owner and the requester as sharers.
- R6: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_type`=2) to the owner. It replies with the fill data, writes that data to memory, and leaves the block exclusive with the requester as the new sole owner.
- R7: A write back (`req_op`=2) from the owner of an exclusive block writes its data to memory and leaves the block uncached with no sharers. It sends no message.
- R8: A write back to a block that is not exclusive, or one from a processor that is not the owner, is ignored. No message is sent and neither memory nor the directory entry changes.
- R9: `req_ready` is 0 from the cycle after a request is accepted until that request's last message has been sent, including the whole wait for a fill. At most one message leaves per cycle, and every message carries the request's block address on `msg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write back |
| req_proc | input | PW | Processor number of the sender |
| req_addr | input | AW | Block index |
| req_data | input | DW | Write-back data |
| fill_valid | input | 1 | Owner's copy returned after a fetch |
| fill_data | input | DW | Returned block data |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dest | output | PW | Destination processor |
| msg_addr | output | AW | Block index of the message |
| msg_data | output | DW | Reply data (data reply only) |

## Verification
Directed sequences run one block through every transition in turn: an uncached read, a write that makes an owner, reads that force a fetch, a write over three sharers that must invalidate them in ascending order while skipping the requester, a stray write back, and a proper owner write back. Each step shows whether the state changed as it should. A long run of seeded random requests then aims many processors at a few blocks. This reaches each state with every operation, so a wrong state update shows up later as an unexpected message or stale data. The bench compares the order of messages, their destinations and their reply data against a reference model. This separates errors in sharer bookkeeping from errors in memory update.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  localparam logic [1:0] DS_UNC = 2'd0;
  localparam logic [1:0] DS_SHR = 2'd1;
  localparam logic [1:0] DS_EXC = 2'd2;

  localparam logic [1:0] RQ_RD = 2'd0;
  localparam logic [1:0] RQ_WR = 2'd1;
  localparam logic [1:0] RQ_WB = 2'd2;

  localparam logic [1:0] MS_INV  = 2'd0;
  localparam logic [1:0] MS_FET  = 2'd1;
  localparam logic [1:0] MS_FINV = 2'd2;
  localparam logic [1:0] MS_DATA = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_EXEC  = 3'd1,
    S_INV   = 3'd2,
    S_WAIT  = 3'd3,
    S_REPLY = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/dirc_prio.sv
module dirc_prio #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/dirc_table.sv
module dirc_table
  import dirc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  output logic [1:0]       rd_state,
  output logic [NPROC-1:0] rd_sharers,
  output logic [DW-1:0]    rd_data,
  input  logic             dir_we,
  input  logic [1:0]       dir_state,
  input  logic [NPROC-1:0] dir_sharers,
  input  logic             mem_we,
  input  logic [DW-1:0]    mem_wdata
);
  logic [NBLK-1:0][1:0]       st_q;
  logic [NBLK-1:0][NPROC-1:0] sh_q;
  logic [NBLK-1:0][DW-1:0]    mem_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic hit;
    assign hit = (addr == AW'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[b] <= DS_UNC;
        sh_q[b] <= '0;
      end else if (dir_we && hit) begin
        st_q[b] <= dir_state;
        sh_q[b] <= dir_sharers;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[b] <= '0;
      end else if (mem_we && hit) begin
        mem_q[b] <= mem_wdata;
      end
    end

    assert_unc_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_UNC) |-> (sh_q[b] == '0));
    assert_exc_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_EXC) |-> ($countones(sh_q[b]) == 1));
    assert_shr_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_SHR) |-> (sh_q[b] != '0));
  end

  assign rd_state   = st_q[addr];
  assign rd_sharers = sh_q[addr];
  assign rd_data    = mem_q[addr];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dirc_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          msg_valid,
  output logic [1:0]    msg_type,
  output logic [PW-1:0] msg_dest,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  ctl_state_e       st_q, st_d;
  logic [1:0]       op_q;
  logic [PW-1:0]    proc_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [NPROC-1:0] pend_q, pend_d;
  logic             pend_en;
  logic             take;

  logic [1:0]       tb_st;
  logic [NPROC-1:0] tb_sh;
  logic [DW-1:0]    tb_mem;
  logic             dir_we, mem_we;
  logic [1:0]       dir_st;
  logic [NPROC-1:0] dir_sh;
  logic [DW-1:0]    mem_wd;

  logic [NPROC-1:0] self_oh;
  logic [NPROC-1:0] others;
  logic             own_found, pnd_found;
  logic [PW-1:0]    own_idx, pnd_idx;
  logic [NPROC-1:0] pnd_oh;

  dirc_table #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n), .addr(addr_q),
    .rd_state(tb_st), .rd_sharers(tb_sh), .rd_data(tb_mem),
    .dir_we(dir_we), .dir_state(dir_st), .dir_sharers(dir_sh),
    .mem_we(mem_we), .mem_wdata(mem_wd)
  );

  dirc_prio #(.N(NPROC)) u_owner (.vec(tb_sh),  .found(own_found), .idx(own_idx));
  dirc_prio #(.N(NPROC)) u_pend  (.vec(pend_q), .found(pnd_found), .idx(pnd_idx));

  assign self_oh   = NPROC'(1) << proc_q;
  assign others    = tb_sh & ~self_oh;
  assign pnd_oh    = NPROC'(1) << pnd_idx;
  assign req_ready = (st_q == S_IDLE);
  assign take      = req_valid && req_ready;
  assign msg_addr  = addr_q;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    pend_en   = 1'b0;
    msg_valid = 1'b0;
    msg_type  = MS_DATA;
    msg_dest  = proc_q;
    msg_data  = '0;
    dir_we    = 1'b0;
    dir_st    = DS_UNC;
    dir_sh    = '0;
    mem_we    = 1'b0;
    mem_wd    = data_q;
    unique case (st_q)
      S_IDLE: if (take) st_d = S_EXEC;
      S_EXEC: begin
        unique case (op_q)
          RQ_RD: begin
            if (tb_st == DS_EXC) begin
              msg_valid = 1'b1;
              msg_type  = MS_FET;
              msg_dest  = own_idx;
              st_d      = S_WAIT;
            end else begin
              st_d = S_REPLY;
            end
          end
          RQ_WR: begin
            if (tb_st == DS_EXC) begin
              msg_valid = 1'b1;
              msg_type  = MS_FINV;
              msg_dest  = own_idx;
              st_d      = S_WAIT;
            end else if ((tb_st == DS_SHR) && (others != '0)) begin
              pend_d  = others;
              pend_en = 1'b1;
              st_d    = S_INV;
            end else begin
              st_d = S_REPLY;
            end
          end
          RQ_WB: begin
            if ((tb_st == DS_EXC) && ((tb_sh & self_oh) != '0)) begin
              mem_we = 1'b1;
              mem_wd = data_q;
              dir_we = 1'b1;
              dir_st = DS_UNC;
              dir_sh = '0;
            end
            st_d = S_IDLE;
          end
          default: st_d = S_IDLE;
        endcase
      end
      S_INV: begin
        msg_valid = pnd_found;
        msg_type  = MS_INV;
        msg_dest  = pnd_idx;
        pend_d    = pend_q & ~pnd_oh;
        pend_en   = 1'b1;
        if ((pend_q & ~pnd_oh) == '0) st_d = S_REPLY;
      end
      S_WAIT: begin
        if (fill_valid) begin
          mem_we = 1'b1;
          mem_wd = fill_data;
          st_d   = S_REPLY;
        end
      end
      S_REPLY: begin
        msg_valid = 1'b1;
        msg_type  = MS_DATA;
        msg_dest  = proc_q;
        msg_data  = tb_mem;
        dir_we    = 1'b1;
        if (op_q == RQ_RD) begin
          dir_st = DS_SHR;
          dir_sh = tb_sh | self_oh;
        end else begin
          dir_st = DS_EXC;
          dir_sh = self_oh;
        end
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= RQ_RD;
      proc_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      op_q   <= req_op;
      proc_q <= req_proc;
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assert_inv_skip_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == MS_INV) |-> (msg_dest != proc_q));
  assert_inv_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == MS_INV) |=>
      (!(msg_valid && msg_type == MS_INV) || (msg_dest > $past(msg_dest))));
  assert_msg_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);
  assert_fill_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (st_q == S_WAIT));
  assert_reply_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && fill_valid) |=>
      (msg_valid && msg_type == MS_DATA && msg_data == $past(fill_data)));
  assert_wb_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EXEC && op_q == RQ_WB) |-> !msg_valid);
endmodule

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  localparam int NP = 4, NB = 8, DW = 16, PW = 2, AW = 3;
  localparam int UNC = 0, SHR = 1, EXC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic req_ready, msg_valid;
  logic [1:0] req_op = '0, msg_type;
  logic [PW-1:0] req_proc = '0, msg_dest;
  logic [AW-1:0] req_addr = '0, msg_addr;
  logic [DW-1:0] req_data = '0, fill_data = '0, msg_data;

  always #4 clk = ~clk;

  dir_home_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
    .fill_valid(fill_valid), .fill_data(fill_data), .msg_valid(msg_valid),
    .msg_type(msg_type), .msg_dest(msg_dest), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int            m_st [NB];
  logic [NP-1:0] m_sh [NB];
  logic [DW-1:0] m_mem[NB];
  logic [DW-1:0] m_cv [NB];

  int            ne;
  logic [1:0]    e_ty[8];
  int            e_ds[8];
  logic [DW-1:0] e_dt[8];
  logic [DW-1:0] fillv;

  function automatic int lowbit(logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic string tag_of(logic [1:0] t);
    case (t)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic push(logic [1:0] t, int d, logic [DW-1:0] v);
    e_ty[ne] = t; e_ds[ne] = d; e_dt[ne] = v; ne++;
  endtask

  task automatic predict(int op, int p, int a, logic [DW-1:0] d);
    logic [NP-1:0] me;
    me = NP'(1) << p;
    ne = 0;
    if (op == 0) begin
      if (m_st[a] == EXC) begin
        push(2'd1, lowbit(m_sh[a]), '0);
        fillv = m_cv[a]; m_mem[a] = fillv;
      end
      push(2'd3, p, m_mem[a]);
      m_sh[a] = m_sh[a] | me; m_st[a] = SHR;
    end else if (op == 1) begin
      if (m_st[a] == EXC) begin
        push(2'd2, lowbit(m_sh[a]), '0);
        fillv = m_cv[a]; m_mem[a] = fillv;
      end else if (m_st[a] == SHR) begin
        for (int i = 0; i < NP; i++) if (m_sh[a][i] && i != p) push(2'd0, i, '0);
      end
      push(2'd3, p, m_mem[a]);
      m_sh[a] = me; m_st[a] = EXC; m_cv[a] = DW'($urandom);
    end else begin
      if (m_st[a] == EXC && m_sh[a][p]) begin
        m_mem[a] = d; m_st[a] = UNC; m_sh[a] = '0;
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(int op, int p, int a, logic [DW-1:0] d);
    int got = 0, cyc = 0;
    bit fpend = 0;
    predict(op, p, a, d);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_proc = PW'(p); req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && cyc < 60) begin
      fill_valid = 1'b0;
      if (fpend) begin fill_valid = 1'b1; fill_data = fillv; fpend = 0; end
      if (msg_valid) begin
        if (got < ne) begin
          check(msg_type == e_ty[got] && int'(msg_dest) == e_ds[got] && int'(msg_addr) == a,
                tag_of(e_ty[got]), "message type/dest/addr",
                {msg_type, 2'b0, msg_dest, 1'b0, msg_addr},
                {e_ty[got], 2'b0, PW'(e_ds[got]), 1'b0, AW'(a)});
          if (e_ty[got] == 2'd3)
            check(msg_data == e_dt[got], (fpend || e_dt[got] == fillv) ? "R5" : "R2",
                  "reply data", msg_data, e_dt[got]);
          if (msg_type == 2'd1 || msg_type == 2'd2) fpend = 1;
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    fill_valid = 1'b0;
    check(got == ne, (op == 2) ? "R8" : "R9", "message count", got, ne);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin
      m_st[b] = UNC; m_sh[b] = '0; m_mem[b] = '0; m_cv[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(msg_valid == 1'b0, "R1", "no message after reset", msg_valid, 0);
    do_req(0, 0, 0, '0);                // R1/R2: uncached read returns zero
    do_req(1, 1, 1, '0);                // R3: uncached write
    do_req(0, 2, 1, '0);                // R5: fetch from owner P1
    do_req(0, 0, 1, '0);                // R2: shared read
    do_req(0, 3, 1, '0);                // R2
    do_req(1, 2, 1, '0);                // R4: inv P0,P1,P3 skipping P2
    do_req(2, 0, 1, 16'hdead);          // R8: write back by non-owner
    do_req(1, 3, 1, '0);                // R6: fetch/inv from P2
    do_req(2, 3, 1, m_cv[1]);           // R7: owner write back
    do_req(2, 3, 1, 16'hbeef);          // R8: write back to uncached
    do_req(0, 1, 1, '0);                // R2/R7: memory holds written-back data
    for (int k = 0; k < 400; k++) begin
      int op, p, a;
      op = int'($urandom % 3); p = int'($urandom % NP); a = int'($urandom % 3);
      if (op == 2 && m_st[a] == EXC && ($urandom % 2) == 0) p = lowbit(m_sh[a]);
      do_req(op, p, a, (op == 2 && m_st[a] == EXC && m_sh[a][p]) ? m_cv[a] : DW'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule